// File: doc/BRIEF.md
# Square-Wave Tone Generator with Note Duration

This block drives a one-bit speaker line with a square wave for a fixed length of time. A single command plays one note. A one-cycle start strobe captures a 16-bit period value and a 16-bit duration value. The block then produces a low half-cycle followed by a high half-cycle, repeating, until the duration has elapsed. At that point it raises a one-cycle completion pulse and parks the line low. A period of zero plays a rest: the line stays low, but the full duration still elapses before completion.

Two free-running prescalers derive the timebases from the system clock. The half-period counter advances on a tick every 4 clock cycles. The duration counter advances on a tick every 256 clock cycles. Both prescaler ratios are parameters. Both prescalers and both counters are cleared by every start strobe, so each note begins from a known phase. A strobe that arrives while a note is playing abandons that note at once and begins the new one. Melody sequencing, the amplifier and any analog shaping sit outside the block.

Top module: `tone_gen`

## Requirements
- R1: After a synchronous reset, and on any cycle with no note in progress, `spk`, `busy` and `done` are all 0; a reset in the middle of a note stops it with no completion pulse.
- R2: For a nonzero period P, the half length is H = (P+1)>>1 period ticks, with one period tick every 4 clock cycles. Counting k clock edges after the start edge, `spk` equals bit 0 of k/(4*H), so the line starts low.
- R3: A period of 0 keeps `spk` at 0 for the whole note, while `busy` and the completion timing are the same as for a tone.
- R4: For a duration D > 0, `busy` is 1 for k < 256*D. At k = 256*D, `done` is 1 for exactly one cycle, `busy` drops, and `spk` is forced to 0.
- R5: A duration of 0 completes immediately: `done` is 1 on the cycle after the start edge, `busy` stays 0, and `spk` never rises.
- R6: A start strobe during a note abandons that note and restarts both prescalers and both counters from the newly captured period and duration.
- R7: The colour note periods 1004, 1265, 1896 and 2388 give half-cycle lengths of 2008, 2532, 3792 and 4776 clock cycles.
- R8: Changes on `period` and `duration` without a start strobe have no effect on a note in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that captures `period` and `duration` and begins a note |
| period | input | 16 | Full tone period in period ticks; 0 plays a rest |
| duration | input | 16 | Note length in duration ticks (256 clocks each) |
| spk | output | 1 | Registered square-wave speaker output |
| busy | output | 1 | High while a note is in progress |
| done | output | 1 | One-cycle pulse when a note completes |

## Verification
Notes are played with small odd and even periods, a period of one, a rest and a zero-length note. The odd period separates correct rounding of the half length from truncation. The period of one exposes an off-by-one in the half-cycle compare. The rest and the zero-length note separate "silent but timed" from "skipped". A note interrupted by a second start shows whether every counter and prescaler restarts. A note whose inputs change without a strobe shows whether the values were latched. The four colour periods, played long enough for several toggles, confirm the long half-cycle counts.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned TONE_W      = 16;
  localparam int unsigned PER_DIV_DEF = 4;
  localparam int unsigned DUR_DIV_DEF = 256;

  // Period values of the four colour notes (period ticks)
  localparam logic [15:0] NOTE_GREEN  = 16'h03EC;
  localparam logic [15:0] NOTE_BLUE   = 16'h04F1;
  localparam logic [15:0] NOTE_YELLOW = 16'h0768;
  localparam logic [15:0] NOTE_RED    = 16'h0954;
endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      assign tick = en && (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt_q <= '0;
        end else if (en) begin
          cnt_q <= tick ? '0 : cnt_q + CW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tone_duration.sv
module tone_duration #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] len,
  input  logic          tick,
  output logic          busy,
  output logic          last,
  output logic          done
);
  logic [DW-1:0] cnt_q, tgt_q;
  logic [DW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + DW'(1);
  assign last   = busy && tick && (cnt_nx == tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      busy  <= (len != '0);
      done  <= (len == '0);
      cnt_q <= '0;
      tgt_q <= len;
    end else begin
      done <= 1'b0;
      if (busy && tick) begin
        cnt_q <= cnt_nx;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] per,
  input  logic          tick,
  input  logic          run,
  input  logic          stop,
  output logic          spk
);
  logic [PW-1:0] half_q, hcnt_q, hcnt_nx;
  logic [PW:0]   rounded;
  logic          silent_q;

  assign rounded = {1'b0, per} + (PW+1)'(1);
  assign hcnt_nx = hcnt_q + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      spk      <= 1'b0;
      silent_q <= 1'b1;
      half_q   <= '0;
      hcnt_q   <= '0;
    end else if (load) begin
      spk      <= 1'b0;
      silent_q <= (per == '0);
      half_q   <= rounded[PW:1];
      hcnt_q   <= '0;
    end else if (!run || stop) begin
      spk <= 1'b0;
    end else if (tick && !silent_q) begin
      if (hcnt_nx == half_q) begin
        hcnt_q <= '0;
        spk    <= ~spk;
      end else begin
        hcnt_q <= hcnt_nx;
      end
    end
  end
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int unsigned PW      = tone_pkg::TONE_W,
  parameter int unsigned DW      = tone_pkg::TONE_W,
  parameter int unsigned PER_DIV = tone_pkg::PER_DIV_DEF,
  parameter int unsigned DUR_DIV = tone_pkg::DUR_DIV_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] period,
  input  logic [DW-1:0] duration,
  output logic          spk,
  output logic          busy,
  output logic          done
);
  logic per_tick, dur_tick, last;

  tone_prescaler #(.DIV(PER_DIV)) u_per_div (
    .clk(clk), .rst(rst), .clr(start), .en(busy), .tick(per_tick)
  );

  tone_prescaler #(.DIV(DUR_DIV)) u_dur_div (
    .clk(clk), .rst(rst), .clr(start), .en(busy), .tick(dur_tick)
  );

  tone_duration #(.DW(DW)) u_dur (
    .clk(clk), .rst(rst), .load(start), .len(duration), .tick(dur_tick),
    .busy(busy), .last(last), .done(done)
  );

  tone_phase #(.PW(PW)) u_phase (
    .clk(clk), .rst(rst), .load(start), .per(period), .tick(per_tick),
    .run(busy), .stop(last), .spk(spk)
  );
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int unsigned PW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [PW-1:0] period,
  input logic [DW-1:0] duration,
  input logic          spk,
  input logic          busy,
  input logic          done
);
  logic rest_q;
  always_ff @(posedge clk) begin
    if (rst)        rest_q <= 1'b1;
    else if (start) rest_q <= (period == '0);
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spk);                                         // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                         // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);                             // R4
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (start && duration == '0) |=> (done && !busy && !spk));  // R5
  AST_REST_QUIET: assert property (@(posedge clk) disable iff (rst)
    rest_q |-> !spk);                                        // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    start |=> !spk);                                         // R2
  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && duration != '0) |=> (busy && !done));          // R6
endmodule

bind tone_gen tone_gen_chk #(.PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .period(period), .duration(duration),
  .spk(spk), .busy(busy), .done(done)
);

// File: tb/tone_gen_bench.sv
module tone_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] period = '0;
  logic [15:0] duration = '0;
  logic spk, busy, done;

  always #5 clk = ~clk;

  tone_gen u_tone_gen (
    .clk(clk), .rst(rst), .start(start), .period(period), .duration(duration),
    .spk(spk), .busy(busy), .done(done)
  );

  // behavioural reference
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    active = 0;
  int    k = 0;
  int    m_per = 0;
  int    m_len = 0;
  bit    finished = 0;

  always @(posedge clk) begin
    if (rst) begin
      active = 0;
    end else if (start) begin
      active = 1;
      k      = 0;
      m_per  = int'(period);
      m_len  = int'(duration) * 256;
    end else if (active && k <= m_len) begin
      k = k + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit e_busy, e_done, e_spk;
      int h;
      e_busy = active && (k < m_len);
      e_done = active && (k == m_len);
      h      = (m_per + 1) / 2;
      e_spk  = e_busy && (m_per != 0) && (((k / (4 * h)) % 2) == 1);
      checks++;
      if (spk !== e_spk || busy !== e_busy || done !== e_done) begin
        errors++;
        $display("FAIL %s at k=%0d: spk/busy/done actual %b%b%b expected %b%b%b",
                 cur_req, k, spk, busy, done, e_spk, e_busy, e_done);
      end
    end
  end

  task automatic play(input logic [15:0] p, input logic [15:0] d, input int wait_n);
    @(negedge clk);
    start = 1'b1; period = p; duration = d;
    @(negedge clk);
    start = 1'b0;
    repeat (wait_n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; repeat (6) @(negedge clk);          // r1_ idle after reset
    cur_req = "R2"; play(16'd5, 16'd2, 520);             // odd period, H=3
    cur_req = "R2"; play(16'd1, 16'd1, 262);             // period one, H=1
    cur_req = "R2"; play(16'd8, 16'd1, 262);             // even period, H=4
    cur_req = "R3"; play(16'd0, 16'd3, 775);             // rest
    cur_req = "R5"; play(16'd5, 16'd0, 8);               // zero length
    cur_req = "R5"; play(16'd2, 16'd0, 0);               // back-to-back zero length
    play(16'd2, 16'd0, 8);
    cur_req = "R6"; play(16'd3, 16'd4, 300);             // abort mid note
    play(16'd6, 16'd1, 270);
    cur_req = "R8"; play(16'd7, 16'd2, 50);              // inputs move without strobe
    period = 16'd2; duration = 16'd9;
    repeat (480) @(negedge clk);
    cur_req = "R7"; play(16'h03EC, 16'd40, 10250);
    play(16'h04F1, 16'd40, 10250);
    play(16'h0768, 16'd40, 10250);
    play(16'h0954, 16'd40, 10250);
    cur_req = "R4"; play(16'd9, 16'd1, 270);             // done pulse, low after
    cur_req = "R1"; play(16'd3, 16'd5, 100);             // reset mid note
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0; repeat (10) @(negedge clk);
    finish_run();
  end
endmodule